// File: doc/BRIEF.md
# Transmit Phase-Align Buffer

This block carries 10-bit transmit characters, each with its odd-parity bit, from a channel's input clock into the internal transmit character clock. The two clocks run at the same frequency, but the phase between them can be anything. An eight-entry elastic store sits between them, so the write side and the read side each run on their own clock.

While the transmit reset is held low, both pointers are cleared. After release, the read side waits until it sees half the depth filled before it starts reading. The spacing between the pointers is therefore centred once, and it then stays fixed for as long as the clocks stay coherent.

If the buffer ever runs dry or fills up, a sticky fault output is raised. It stays set until the next reset or until a word-sync-done strobe arrives. In the bypass configuration, the input register is clocked by the reference clock itself. The buffer is then skipped: characters are registered straight onto the output, and the fault is never raised.

Top module: `tx_phase_align_buf`

## Requirements
- R1: With no fault, the read side delivers every character the write side accepted, in order, with no repeats and no gaps.
- R2: After reset is released, the output holds zero until the read side sees at least DEPTH/2 (4) stored entries. After that it reads one entry per read clock, and with equal-rate clocks no fault is raised.
- R3: On underflow, meaning a read is due but nothing is stored, the output repeats the last character and the fault output rises one read clock later.
- R4: While the store holds DEPTH (8) entries, an incoming character is dropped. The read side flags the drop as an overflow fault. The characters already held are still delivered in order, and a gap follows them.
- R5: The fault stays high until a one-read-clock-wide word_sync_done strobe is seen. It is low from the read clock edge that samples the strobe.
- R6: While tx_rst_n is low, the fault is low and the output character is zero. The stored contents are discarded.
- R7: When bypass_en is high, the output is the input character sampled on the previous read clock edge, and the fault never rises.
- R8: Output format: rd_data carries the 10 character bits and rd_par carries the parity bit that entered with them. The bench drives odd parity, so rd_par equals the inverted XOR of the 10 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Channel input clock (write side) |
| rd_clk | input | 1 | Internal transmit character clock (read side) |
| tx_rst_n | input | 1 | Transmit reset, active low. Sampled synchronously in both clock domains. |
| bypass_en | input | 1 | Static. High when the input register runs on the reference clock at full rate. |
| wr_data | input | 10 | Character to transmit |
| wr_par | input | 1 | Parity bit of the character |
| word_sync_done | input | 1 | Single read-clock strobe: a word-sync sequence has been sent |
| rd_data | output | 10 | Character toward the shifter |
| rd_par | output | 1 | Parity bit travelling with rd_data |
| fault | output | 1 | Sticky underflow/overflow indication |

## Verification
A character written at a write edge reaches the output no earlier than four writes plus two read-side synchronizer stages after release. The monitor therefore never times characters; it checks them by order against a scoreboard queue, and it aligns on the first non-zero output. The output is still zero two read cycles after release. Underflow raises the fault within about seven read cycles of the write clock stopping, and a missed overflow raises it within three read cycles of the read clock resuming. Both are sampled at least twelve cycles later. The strobe clears the fault at the very next read edge, and bypass output follows its input by exactly one read edge; those two are sampled on the first falling edge after they are due.

// File: rtl/tpab_pkg.sv
// Shared definitions for the transmit phase-align buffer.
package tpab_pkg;
    localparam int CHAR_W = 10;

    // Read-side state: waiting to reach mid-depth, or reading freely.
    typedef enum logic {
        RD_PRIME = 1'b0,
        RD_RUN   = 1'b1
    } rd_state_e;
endpackage

// File: rtl/tpab_sync.sv
// Multi-stage synchronizer for a Gray-coded or single-bit signal.
// Assumes the source changes at most one bit per source clock.
// Reset is synchronous and active low, in the destination domain.
module tpab_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Flop chain, stage 0 samples the foreign-domain value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tpab_wr_side.sv
// Write side of the phase-align buffer: storage array, write pointer,
// full check against the synchronized read pointer, and a toggle that
// marks the start of each episode in which characters are dropped.
// Assumes rgray_s is already in this clock domain.
module tpab_wr_side #(
    parameter int WORD_W = 11,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic [PW-1:0]     rgray_s,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdat,
    output logic [PW-1:0]     wgray,
    output logic              drop_tgl
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wbin, wnext, rbin_s, fill;
    logic              full, full_q;

    // Convert the synchronized read pointer back to binary.
    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    assign wnext = wbin + 1'b1;
    assign fill  = wbin - rbin_s;
    assign full  = (fill == PW'(DEPTH));

    // Advance the write pointer, binary and Gray, unless full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (!full) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    // Store the incoming character when there is room.
    always_ff @(posedge clk) begin
        if (rst_n && !full) mem[wbin[AW-1:0]] <= din;
    end

    // Flip the drop toggle once per continuous full episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= 1'b0;
            drop_tgl <= 1'b0;
        end else begin
            full_q <= full;
            if (full && !full_q) drop_tgl <= ~drop_tgl;
        end
    end

    assign rdat = mem[raddr];

    AST_WR_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH)); // R4
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R1
endmodule

// File: rtl/tpab_rd_side.sv
// Read side of the phase-align buffer: mid-depth priming after reset,
// one read per clock, repeat of the last character on underflow,
// overflow detection from the write side's drop toggle, and the
// bypass path. Assumes bypass is static and its inputs are synchronous
// to this clock when it is set.
module tpab_rd_side
    import tpab_pkg::*;
#(
    parameter int WORD_W = 11,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic [PW-1:0]     wgray_s,
    input  logic              drop_tgl_s,
    input  logic [WORD_W-1:0] rdat,
    input  logic [WORD_W-1:0] byp_word,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [WORD_W-1:0] dout,
    output logic              uflow,
    output logic              oflow
);
    rd_state_e     state;
    logic [PW-1:0] rbin, rnext, wbin_s, occ;
    logic          tgl_q;

    // Convert the synchronized write pointer back to binary.
    always_comb begin
        wbin_s[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    assign rnext = rbin + 1'b1;
    assign occ   = wbin_s - rbin;
    assign raddr = rbin[AW-1:0];

    // Prime to mid-depth, then read one character per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_PRIME;
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
        end else if (bypass) begin
            dout <= byp_word;
        end else begin
            unique case (state)
                RD_PRIME: begin
                    if (occ >= PW'(HALF)) begin
                        dout  <= rdat;
                        rbin  <= rnext;
                        rgray <= rnext ^ (rnext >> 1);
                        state <= RD_RUN;
                    end
                end
                RD_RUN: begin
                    if (occ != '0) begin
                        dout  <= rdat;
                        rbin  <= rnext;
                        rgray <= rnext ^ (rnext >> 1);
                    end
                end
            endcase
        end
    end

    // Remember the last drop toggle value to spot a new episode.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= drop_tgl_s;
    end

    assign uflow = !bypass && (state == RD_RUN) && (occ == '0);
    assign oflow = !bypass && (drop_tgl_s ^ tgl_q);

    AST_UFLOW_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> $stable(dout)); // R3
    AST_RD_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH)); // R4
    AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && state == RD_PRIME && occ < PW'(HALF)) |=> $stable(dout)); // R2
endmodule

// File: rtl/tpab_fault.sv
// Sticky fault flag in the read domain. An error sets it. A word-sync
// strobe clears it, but a new error in the same cycle wins. Reset clears it.
module tpab_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic clr,
    output logic fault
);
    // Set on error, clear on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   fault <= 1'b0;
        else if (err) fault <= 1'b1;
        else if (clr) fault <= 1'b0;
    end

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr) |=> fault); // R5
    AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> fault); // R3
endmodule

// File: rtl/tx_phase_align_buf.sv
// Transmit phase-align buffer top. It joins the write side, the read
// side, pointer synchronizers in both directions and the sticky fault.
// Assumes wr_clk and rd_clk are frequency-coherent, and that tx_rst_n
// is held low for several cycles of both clocks.
module tx_phase_align_buf
    import tpab_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = CHAR_W + 1,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              tx_rst_n,
    input  logic              bypass_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic              word_sync_done,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_par,
    output logic              fault
);
    logic [WORD_W-1:0] rdat, dout;
    logic [PW-1:0]     wgray, wgray_s, rgray, rgray_s;
    logic [AW-1:0]     raddr;
    logic              drop_tgl, drop_tgl_s, uflow, oflow;

    tpab_wr_side #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(tx_rst_n), .din({wr_par, wr_data}),
        .rgray_s(rgray_s), .raddr(raddr), .rdat(rdat),
        .wgray(wgray), .drop_tgl(drop_tgl)
    );

    tpab_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rd_clk), .rst_n(tx_rst_n), .d(wgray), .q(wgray_s)
    );

    tpab_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_drop (
        .clk(rd_clk), .rst_n(tx_rst_n), .d(drop_tgl), .q(drop_tgl_s)
    );

    tpab_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wr_clk), .rst_n(tx_rst_n), .d(rgray), .q(rgray_s)
    );

    tpab_rd_side #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(tx_rst_n), .bypass(bypass_en),
        .wgray_s(wgray_s), .drop_tgl_s(drop_tgl_s), .rdat(rdat),
        .byp_word({wr_par, wr_data}), .raddr(raddr), .rgray(rgray),
        .dout(dout), .uflow(uflow), .oflow(oflow)
    );

    tpab_fault u_fault (
        .clk(rd_clk), .rst_n(tx_rst_n), .err(uflow | oflow),
        .clr(word_sync_done), .fault(fault)
    );

    assign rd_data = dout[CHAR_W-1:0];
    assign rd_par  = dout[CHAR_W];

    AST_BYPASS_CLEAN: assert property (@(posedge rd_clk) disable iff (!tx_rst_n)
        (bypass_en && !fault) |=> !fault); // R7
endmodule

// File: tb/test_tx_phase_align_buf.sv
`timescale 1ns/1ps
module test_tx_phase_align_buf;
    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    bit         wr_run = 1'b1, rd_run = 1'b1;
    logic       tx_rst_n, bypass_en, wr_par, word_sync_done;
    logic [9:0] wr_data;
    logic [9:0] rd_data;
    logic       rd_par, fault;

    int         n_vec = 0, n_bad = 0;
    logic [10:0] exp_q [$];
    bit         drv_en = 1'b0, aligned = 1'b0, skip_seen = 1'b0;
    int         mon_mode = 0;   // 0 off, 1 strict order, 2 repeats/gaps allowed
    logic [10:0] last_got = '0;
    logic [9:0] cnt = '0;

    tx_phase_align_buf i_tx_phase_align_buf (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .tx_rst_n(tx_rst_n),
        .bypass_en(bypass_en), .wr_data(wr_data), .wr_par(wr_par),
        .word_sync_done(word_sync_done), .rd_data(rd_data),
        .rd_par(rd_par), .fault(fault)
    );

    // 200 MHz clocks; the write clock is offset in phase and both can pause.
    initial begin
        #1.7;
        forever begin #2.5; if (wr_run) wr_clk = ~wr_clk; end
    end
    initial forever begin #2.5; if (rd_run) rd_clk = ~rd_clk; end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Driver: present the next character and record what should come out.
    task automatic drive_one();
        cnt     = cnt + 1'b1;
        wr_data = cnt;
        wr_par  = ~^cnt;
        exp_q.push_back({~^cnt, cnt});
    endtask

    initial forever begin
        @(negedge wr_clk);
        if (drv_en) drive_one();
    end

    // Monitor: compare the read-side characters with the scoreboard queue.
    task automatic mon_step();
        logic [10:0] got;
        int          skipped;
        got = {rd_par, rd_data};
        if (!aligned) begin
            if (got != '0) begin
                while (exp_q.size() > 0 && exp_q[0] != got) void'(exp_q.pop_front());
                chk(exp_q.size() > 0, "R1", "first character not in queue", got, 0);
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                aligned  = 1'b1;
                last_got = got;
            end
        end else if (mon_mode == 1) begin
            chk(exp_q.size() > 0 && got == exp_q[0], "R1", "in-order character",
                got, exp_q.size() > 0 ? exp_q[0] : 0);
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            last_got = got;
        end else if (got != last_got) begin
            skipped = 0;
            while (exp_q.size() > 0 && exp_q[0] != got) begin
                void'(exp_q.pop_front());
                skipped++;
            end
            chk(exp_q.size() > 0, "R4", "character order after fault", got, 0);
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            if (skipped > 0) skip_seen = 1'b1;
            last_got = got;
        end
    endtask

    initial forever begin
        @(negedge rd_clk);
        if (mon_mode != 0) mon_step();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200us;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [10:0] held;
        logic [10:0] prev;
        tx_rst_n = 1'b0; bypass_en = 1'b0; word_sync_done = 1'b0;
        wr_data = '0; wr_par = 1'b0;
        drv_en = 1'b1;
        repeat (10) @(negedge rd_clk);
        chk(fault == 1'b0, "R6", "fault in reset", fault, 0);
        chk({rd_par, rd_data} == '0, "R6", "output in reset", {rd_par, rd_data}, 0);

        // Release and prime: the output stays zero until mid-depth is reached.
        tx_rst_n = 1'b1; aligned = 1'b0; mon_mode = 1;
        repeat (2) @(negedge rd_clk);
        chk({rd_par, rd_data} == '0, "R2", "output before priming", {rd_par, rd_data}, 0);
        repeat (150) @(negedge rd_clk);
        chk(fault == 1'b0, "R2", "no fault at equal rate", fault, 0);
        chk(aligned, "R1", "stream started", aligned, 1);

        // Underflow: stop the write clock.
        mon_mode = 2;
        wr_run = 1'b0;
        repeat (20) @(negedge rd_clk);
        chk(fault == 1'b1, "R3", "fault after underflow", fault, 1);
        held = {rd_par, rd_data};
        repeat (3) @(negedge rd_clk);
        chk({rd_par, rd_data} == held, "R3", "last character repeated", {rd_par, rd_data}, held);
        wr_run = 1'b1;
        repeat (30) @(negedge rd_clk);
        chk(fault == 1'b1, "R5", "fault sticky after recovery", fault, 1);
        word_sync_done = 1'b1;
        @(negedge rd_clk);
        word_sync_done = 1'b0;
        chk(fault == 1'b0, "R5", "fault cleared by word-sync strobe", fault, 0);
        repeat (10) @(negedge rd_clk);

        // Re-centre with reset, then overflow by stopping the read clock.
        mon_mode = 0; tx_rst_n = 1'b0;
        repeat (8) @(negedge rd_clk);
        exp_q.delete(); aligned = 1'b0;
        tx_rst_n = 1'b1; mon_mode = 1;
        repeat (60) @(negedge rd_clk);
        chk(fault == 1'b0, "R1", "no fault after re-centring", fault, 0);
        mon_mode = 2; skip_seen = 1'b0;
        rd_run = 1'b0;
        repeat (20) @(negedge wr_clk);
        rd_run = 1'b1;
        repeat (12) @(negedge rd_clk);
        chk(fault == 1'b1, "R4", "fault after overflow", fault, 1);
        repeat (40) @(negedge rd_clk);
        chk(skip_seen, "R4", "dropped characters leave a gap", skip_seen, 1);
        chk(fault == 1'b1, "R5", "overflow fault sticky", fault, 1);

        // Reset clears the fault and the output.
        mon_mode = 0; tx_rst_n = 1'b0;
        repeat (8) @(negedge rd_clk);
        chk(fault == 1'b0, "R6", "reset clears fault", fault, 0);
        chk({rd_par, rd_data} == '0, "R6", "reset clears output", {rd_par, rd_data}, 0);

        // Bypass: one read-clock register, never a fault.
        bypass_en = 1'b1; drv_en = 1'b0; wr_run = 1'b0;
        repeat (2) @(negedge rd_clk);
        tx_rst_n = 1'b1;
        prev = '0;
        for (int i = 0; i < 10; i++) begin
            logic [9:0] v;
            v = 10'((i * 10'h1A7) ^ (i << 6));
            if (i == 3) v = 10'h3FF;
            if (i == 7) v = 10'h2A5;
            wr_data = v; wr_par = ~^v;
            prev = {~^v, v};
            @(negedge rd_clk);
            chk({rd_par, rd_data} == prev, "R7", "bypass output", {rd_par, rd_data}, prev);
            chk(rd_par == ~^rd_data, "R8", "parity bit position", rd_par, ~^rd_data);
        end
        chk(fault == 1'b0, "R7", "no fault in bypass", fault, 0);
        summary();
    end
endmodule